// File: doc/BRIEF.md
# Validated Receive Message Commit Buffer

This block sits between a serial command/response bus receiver and a shared 2K-word message RAM. The receiver hands it a captured command word (transmit/receive flag, 5-bit subaddress, 5-bit word count), then a stream of decoded 16-bit data words. Each word comes with a valid strobe or an error strobe, and an end-of-message strobe follows. The block holds the words of one receive message in a local staging FIFO. It copies them into the RAM block for that subaddress only when the whole message has arrived intact, with exactly the commanded number of words.

A message that is short, long, or carries a bad word is thrown away and flagged. The RAM block it was aimed at keeps its previous contents, so the host only ever reads complete, current blocks. A single grant input stands in for the RAM arbiter: the block writes one staged word in each cycle the grant is high, and it pulses a completion strobe once the block has been written.

Top module: `rx_commit_buf`

## Requirements
- R1: In the idle state, a command strobe is accepted only when the transmit/receive flag is 0 (receive) and the subaddress is in 1..30. Commands with the flag at 1, or with subaddress 0 or 31, are ignored, and the data words and end strobe that follow them cause no RAM write, no error pulse and no done pulse.
- R2: A word count field of 0 stands for 32 data words. Any other value n stands for n words.
- R3: The k-th accepted data word (k counted from 0) of a committed message is written to RAM address {1'b0, subaddress[4:0], k[4:0]}. Bit 10 is 0 for the receive half. Words are written in arrival order.
- R4: No RAM write occurs while a message is being collected. Writes start only in the cycle after the end strobe of a message whose word count matches and which saw no error.
- R5: An error strobe during collection discards the message, with no RAM write. msgError is high for exactly the one cycle after the cycle in which the error strobe was sampled. Data words and end strobes that follow are ignored until the next accepted command.
- R6: If the end strobe arrives after fewer words than the count, the message is discarded, with no RAM write, and msgError pulses for one cycle.
- R7: If more data words arrive than the count, the message is discarded at the end strobe, with no RAM write, and msgError pulses for one cycle.
- R8: During commit, ramWe is high exactly in the cycles where grant is high, until all words are written. While grant is low, the write is held back.
- R9: msgDone is high for exactly one cycle, the cycle directly after the last RAM write of a message.
- R10: A data word and the end strobe in the same cycle count that word as part of the message. An error strobe in the same cycle as the end strobe makes the message fail.
- R11: Command strobes, data words and end strobes that arrive while a commit is in progress or during its done cycle are ignored.
- R12: After reset, ramWe, msgDone and msgError are low, and the block waits for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command word strobe |
| cmdTr | input | 1 | Transmit/receive flag of the command (0 = receive) |
| cmdSubaddr | input | 5 | Subaddress field of the command |
| cmdWordCount | input | 5 | Word count field (0 means 32) |
| wordValid | input | 1 | Good data word strobe |
| wordError | input | 1 | Bad data word strobe |
| wordData | input | 16 | Decoded data word |
| msgEnd | input | 1 | End-of-message strobe |
| grant | input | 1 | RAM port grant from the arbiter |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 11 | RAM write address |
| ramWData | output | 16 | RAM write data |
| msgDone | output | 1 | One-cycle pulse after the last committed write |
| msgError | output | 1 | One-cycle pulse when a message is discarded |

## Verification
The end of a message can fall in the same cycle as its last data word, or in the same cycle as an error strobe. The first must still commit, counting that word. The second must discard the message. The bench provokes both on purpose: it sends a full 32-word message whose final word carries the end strobe, and a message whose error strobe coincides with the end strobe. A behavioural queue model judges every cycle's strobes, addresses and data. A shadow of the RAM, compared block by block, confirms that the failed message left the previous contents in place.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  typedef struct packed {
    logic latchCmd;
    logic flush;
    logic push;
    logic pop;
  } rxcStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_COMMIT  = 2'd2,
    ST_DONE    = 2'd3
  } rxcState_t;

endpackage

// File: rtl/rxc_datapath.sv
module rxc_datapath
  import rxc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SA_W   = 5,
  parameter int IDX_W  = 5,
  localparam int CNT_W  = IDX_W + 1,
  localparam int DEPTH  = 1 << IDX_W,
  localparam int ADDR_W = 1 + SA_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxcStrobes_t       stb,
  input  logic [SA_W-1:0]   cmdSubaddr,
  input  logic [IDX_W-1:0]  cmdWordCount,
  input  logic [DATA_W-1:0] wordData,
  output logic [CNT_W-1:0]  rxCount,
  output logic [CNT_W-1:0]  expCount,
  output logic [CNT_W-1:0]  rdCount,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWData
);

  logic [SA_W-1:0]   saReg;
  logic [CNT_W-1:0]  expReg;
  logic [CNT_W-1:0]  wrPtr;
  logic [CNT_W-1:0]  rdPtr;
  logic [DATA_W-1:0] stage [DEPTH];

  // command register: subaddress and decoded word count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      saReg  <= '0;
      expReg <= '0;
    end else if (stb.latchCmd) begin
      saReg  <= cmdSubaddr;
      expReg <= (cmdWordCount == '0) ? CNT_W'(DEPTH) : {1'b0, cmdWordCount};
    end
  end

  // staging FIFO pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + CNT_W'(1);
      if (stb.pop)  rdPtr <= rdPtr + CNT_W'(1);
    end
  end

  // staging storage, no reset needed
  always_ff @(posedge clk) begin
    if (stb.push) stage[wrPtr[IDX_W-1:0]] <= wordData;
  end

  assign rxCount  = wrPtr;
  assign expCount = expReg;
  assign rdCount  = rdPtr;
  assign ramAddr  = {1'b0, saReg, rdPtr[IDX_W-1:0]};
  assign ramWData = stage[rdPtr[IDX_W-1:0]];

endmodule

// File: rtl/rxc_control.sv
module rxc_control
  import rxc_pkg::*;
#(
  parameter int SA_W  = 5,
  parameter int IDX_W = 5,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdTr,
  input  logic [SA_W-1:0]  cmdSubaddr,
  input  logic             wordValid,
  input  logic             wordError,
  input  logic             msgEnd,
  input  logic             grant,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] expCount,
  input  logic [CNT_W-1:0] rdCount,
  output rxcStrobes_t      stb,
  output logic             ramWe,
  output logic             msgDone,
  output logic             msgError
);

  rxcState_t  state, stateNext;
  logic       tooMany, tooManyNext;
  logic       errReg, setErr;
  logic       cmdOk, roomLeft, wordFits, endGood, lastPop;
  logic [CNT_W-1:0] endCount;

  always_comb begin
    cmdOk    = cmdValid && !cmdTr && (cmdSubaddr != '0) && (cmdSubaddr != '1);
    roomLeft = rxCount < expCount;
    wordFits = wordValid && roomLeft;
    endCount = rxCount + CNT_W'(wordFits);
    endGood  = !tooMany && !(wordValid && !roomLeft) && (endCount == expCount);
    lastPop  = rdCount == (expCount - CNT_W'(1));
  end

  always_comb begin
    stateNext   = state;
    stb         = '0;
    setErr      = 1'b0;
    tooManyNext = tooMany;
    unique case (state)
      ST_IDLE: begin
        if (cmdOk) begin
          stb.latchCmd = 1'b1;
          stb.flush    = 1'b1;
          tooManyNext  = 1'b0;
          stateNext    = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (wordError) begin
          stb.flush = 1'b1;
          setErr    = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stb.push = wordFits;
          if (wordValid && !roomLeft) tooManyNext = 1'b1;
          if (msgEnd) begin
            if (endGood) begin
              stateNext = ST_COMMIT;
            end else begin
              stb.push  = 1'b0;
              stb.flush = 1'b1;
              setErr    = 1'b1;
              stateNext = ST_IDLE;
            end
          end
        end
      end
      ST_COMMIT: begin
        if (grant) begin
          stb.pop = 1'b1;
          if (lastPop) stateNext = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tooMany <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      state   <= stateNext;
      tooMany <= tooManyNext;
      errReg  <= setErr;
    end
  end

  assign ramWe    = stb.pop;
  assign msgDone  = state == ST_DONE;
  assign msgError = errReg;

endmodule

// File: rtl/rx_commit_buf.sv
module rx_commit_buf
  import rxc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SA_W   = 5,
  parameter int IDX_W  = 5,
  localparam int CNT_W  = IDX_W + 1,
  localparam int ADDR_W = 1 + SA_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdTr,
  input  logic [SA_W-1:0]   cmdSubaddr,
  input  logic [IDX_W-1:0]  cmdWordCount,
  input  logic              wordValid,
  input  logic              wordError,
  input  logic [DATA_W-1:0] wordData,
  input  logic              msgEnd,
  input  logic              grant,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWData,
  output logic              msgDone,
  output logic              msgError
);

  rxcStrobes_t      stb;
  logic [CNT_W-1:0] rxCount, expCount, rdCount;

  rxc_control #(.SA_W(SA_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdTr(cmdTr), .cmdSubaddr(cmdSubaddr),
    .wordValid(wordValid), .wordError(wordError), .msgEnd(msgEnd),
    .grant(grant),
    .rxCount(rxCount), .expCount(expCount), .rdCount(rdCount),
    .stb(stb), .ramWe(ramWe), .msgDone(msgDone), .msgError(msgError)
  );

  rxc_datapath #(.DATA_W(DATA_W), .SA_W(SA_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cmdSubaddr(cmdSubaddr), .cmdWordCount(cmdWordCount), .wordData(wordData),
    .rxCount(rxCount), .expCount(expCount), .rdCount(rdCount),
    .ramAddr(ramAddr), .ramWData(ramWData)
  );

endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
  parameter int SA_W   = 5,
  parameter int IDX_W  = 5,
  localparam int ADDR_W = 1 + SA_W + IDX_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              grant,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              msgDone,
  input logic              msgError
);

  // R9
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |-> $past(ramWe));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |=> !msgDone);

  // R8
  write_needs_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> grant);

  // R3
  rx_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> !ramAddr[ADDR_W-1]);

  // R1
  no_mode_sa_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr[ADDR_W-2 -: SA_W] != '0) && (ramAddr[ADDR_W-2 -: SA_W] != '1));

  // R5
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgError |=> !msgError);

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgError |-> !msgDone && !ramWe);

endmodule

bind rx_commit_buf rxc_checker #(.SA_W(SA_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rstN(rstN), .grant(grant), .ramWe(ramWe),
  .ramAddr(ramAddr), .msgDone(msgDone), .msgError(msgError)
);

// File: tb/rx_commit_buf_tb.sv
module rx_commit_buf_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 0, cmdTr = 0, wordValid = 0, wordError = 0, msgEnd = 0, grant = 0;
  logic [4:0]  cmdSubaddr = '0, cmdWordCount = '0;
  logic [15:0] wordData = '0;
  logic        ramWe, msgDone, msgError;
  logic [10:0] ramAddr;
  logic [15:0] ramWData;

  int checks = 0, fails = 0, cycleNo = 0;
  string curTag = "R12";
  bit grantAlt = 0;
  bit finished = 0;

  // behavioural reference state
  int mState = 0, mSa = 0, mExp = 0, mIdx = 0;
  bit mOver = 0, mErr = 0;
  logic [15:0] mQ[$];
  logic [15:0] refMem [2048];
  logic [15:0] dutMem [2048];
  int salt = 100;

  always #10 clk = ~clk;

  rx_commit_buf dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdTr(cmdTr),
    .cmdSubaddr(cmdSubaddr), .cmdWordCount(cmdWordCount),
    .wordValid(wordValid), .wordError(wordError), .wordData(wordData),
    .msgEnd(msgEnd), .grant(grant), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWData(ramWData), .msgDone(msgDone), .msgError(msgError)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cycleNo);
    end
  endtask

  task automatic modelStep();
    bit errNow = 0;
    case (mState)
      0: if (cmdValid && !cmdTr && cmdSubaddr != 0 && cmdSubaddr != 31) begin
           mSa = cmdSubaddr; mExp = (cmdWordCount == 0) ? 32 : int'(cmdWordCount);
           mQ.delete(); mOver = 0; mState = 1;
         end
      1: if (wordError) begin errNow = 1; mState = 0; end
         else begin
           if (wordValid) begin
             if (mQ.size() < mExp) mQ.push_back(wordData); else mOver = 1;
           end
           if (msgEnd) begin
             if (!mOver && mQ.size() == mExp) begin mState = 2; mIdx = 0; end
             else begin errNow = 1; mState = 0; end
           end
         end
      2: if (grant) begin
           refMem[mSa*32 + mIdx] = mQ[mIdx];
           mIdx++;
           if (mIdx == mExp) mState = 3;
         end
      default: mState = 0;
    endcase
    mErr = errNow;
  endtask

  task automatic cyc(bit cv, bit tr, logic [4:0] sa, logic [4:0] wc,
                     bit wv, bit we, logic [15:0] d, bit me);
    bit expWe;
    @(negedge clk);
    cmdValid = cv; cmdTr = tr; cmdSubaddr = sa; cmdWordCount = wc;
    wordValid = wv; wordError = we; wordData = d; msgEnd = me;
    grant = grantAlt ? cycleNo[0] : 1'b1;
    #5;
    expWe = (mState == 2) && grant;
    chk(curTag, "ramWe", ramWe, expWe);
    chk(curTag, "msgDone", msgDone, mState == 3);
    chk(curTag, "msgError", msgError, mErr);
    if (expWe && ramWe) begin
      chk(curTag, "ramAddr", ramAddr, mSa*32 + mIdx);
      chk(curTag, "ramWData", ramWData, mQ[mIdx]);
    end
    if (ramWe) dutMem[ramAddr] = ramWData;
    @(posedge clk);
    cycleNo++;
    modelStep();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // send one message: n words, optional error at index errAt,
  // end strobe either with the last word or in a cycle of its own
  task automatic msg(string tag, bit tr, int sa, int wc, int n, int errAt,
                     bit endWithLast, int idleAfter);
    curTag = tag;
    salt += 53;
    cyc(1, tr, 5'(sa), 5'(wc), 0, 0, 0, 0);
    for (int i = 0; i < n; i++)
      cyc(0, 0, 0, 0, 1, i == errAt, 16'(salt * 7 + i * 331), endWithLast && i == n - 1);
    if (!endWithLast || n == 0) cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(idleAfter);
  endtask

  task automatic checkBlock(string tag, int sa);
    bit same = 1;
    checks++;
    for (int w = 0; w < 32; w++)
      if (dutMem[sa*32 + w] !== refMem[sa*32 + w]) begin
        if (same)
          $display("FAIL %s block %0d word %0d actual=%0h expected=%0h",
                   tag, sa, w, dutMem[sa*32 + w], refMem[sa*32 + w]);
        same = 0;
      end
    if (!same) fails++;
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin refMem[i] = '0; dutMem[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12", "ramWe at reset", ramWe, 0);
    chk("R12", "msgDone at reset", msgDone, 0);
    chk("R12", "msgError at reset", msgError, 0);
    rstN = 1'b1;
    curTag = "R12";
    idle(3);

    msg("R3", 0, 5, 4, 4, -1, 0, 8);          // plain message
    checkBlock("R3", 5);
    msg("R4", 0, 7, 3, 3, -1, 0, 8);
    checkBlock("R4", 7);
    msg("R2", 0, 12, 0, 32, -1, 1, 40);       // count 0 = 32, end with last word (R10)
    checkBlock("R2", 12);
    msg("R10", 0, 5, 4, 4, 3, 1, 8);          // error together with end
    checkBlock("R10", 5);
    msg("R5", 0, 5, 4, 4, 1, 0, 8);           // error mid message, rest ignored
    checkBlock("R5", 5);
    msg("R6", 0, 5, 4, 2, -1, 0, 8);          // too few
    checkBlock("R6", 5);
    msg("R7", 0, 5, 4, 6, -1, 0, 8);          // too many
    checkBlock("R7", 5);
    msg("R1", 1, 6, 4, 4, -1, 0, 8);          // transmit command ignored
    checkBlock("R1", 6);
    msg("R1", 0, 0, 4, 4, -1, 0, 8);          // subaddress 0 ignored
    checkBlock("R1", 0);
    msg("R1", 0, 31, 4, 4, -1, 0, 8);         // subaddress 31 ignored
    checkBlock("R1", 31);
    grantAlt = 1;
    msg("R8", 0, 20, 9, 9, -1, 0, 25);        // stalled commit
    checkBlock("R8", 20);
    grantAlt = 0;
    msg("R9", 0, 30, 1, 1, -1, 1, 6);         // single word
    checkBlock("R9", 30);
    // R11: traffic during commit is ignored
    msg("R11", 0, 9, 6, 6, -1, 0, 0);
    cyc(1, 0, 5'd10, 5'd2, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 16'hBEEF, 0);
    cyc(0, 0, 0, 0, 1, 0, 16'hCAFE, 1);
    idle(10);
    checkBlock("R11", 9);
    checkBlock("R11", 10);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule